// File: doc/BRIEF.md
# Bit-Serial Two's-Complement Subtractor (LSB First)

This block subtracts one serial operand from another, one bit position per clock. On every rising edge where the enable is high it samples one bit of the minuend and one bit of the subtrahend, least-significant bit first. It produces one bit of the difference on a registered output and carries a single borrow bit forward to the next position. A word of any length is processed by holding the enable high for as many clocks as the word has bits.

Dropping the enable for a clock ends a word. The output then reads zero and the borrow is cleared, so the next word starts with no borrow pending. The borrow register is also brought out as a status pin. Read in the cycle after the last bit of a word, it shows whether the minuend was smaller than the subtrahend as unsigned numbers. Word-length counting and conversion to or from parallel form are left to the surrounding logic.

Top module: `sersub_lsb`

## Requirements
- R1: When `en_i` is high at a rising edge, `diff_o` after that edge equals `a_i` xor `b_i` xor the `borrow_o` value seen before that edge.
- R2: When `en_i` is high at a rising edge, `borrow_o` after that edge is 1 exactly when (not a and b) or (not a and borrow) or (b and borrow) held before the edge. After bit i of a word, `borrow_o` is 1 exactly when the low i+1 bits of A, taken as unsigned, are less than those of B.
- R3: When `en_i` is low at a rising edge, `diff_o` is 0 after that edge.
- R4: When `en_i` is low at a rising edge, `borrow_o` is 0 after that edge, so the following word begins with no borrow.
- R5: With `rst_i` high at a rising edge, both `diff_o` and `borrow_o` are 0 after that edge, whatever the borrow was before.
- R6: In the cycle after the final bit of an N-bit word, `borrow_o` is 1 exactly when A < B as unsigned N-bit numbers.
- R7: Over an N-bit word fed LSB first with `en_i` held high, the bits seen on `diff_o` form (A - B) mod 2^N, LSB first, each bit appearing one clock after its operand bits are sampled.
- R8: Operand values presented while `en_i` is low have no effect: `diff_o` and `borrow_o` both read 0 after such a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Operation enable; low clears the output and the borrow |
| a_i | input | 1 | Minuend bit, LSB first |
| b_i | input | 1 | Subtrahend bit, LSB first |
| diff_o | output | 1 | Registered difference bit |
| borrow_o | output | 1 | Current borrow; after the last bit it flags A < B |

## Verification
Two things can land on the same edge. One is an enable-low cycle that clears the borrow. The other is the last bit of a word that leaves a borrow of 1 pending. The bench provokes this by sending words whose final bit borrows, followed directly by an idle cycle with random operand bits. It judges the result by requiring the status to read 1 for exactly one clock and then 0, with a zero output. A reset that arrives while a long borrow chain is in flight is handled the same way: the bench expects both registers to be zero right after that edge.

// File: rtl/sersub_pkg.sv
package sersub_pkg;

    // One bit position of the two operands.
    typedef struct packed {
        logic minu;
        logic subt;
    } opnd_t;

    // Result of one full-subtractor step.
    typedef struct packed {
        logic diff;
        logic bout;
    } step_t;

    // Register contents carried between clocks.
    typedef struct packed {
        logic diff;
        logic borrow;
    } state_t;

    localparam state_t STATE_CLEAR = '{diff: 1'b0, borrow: 1'b0};

    function automatic step_t fs_step(input opnd_t op, input logic bin);
        step_t r;
        r.diff = op.minu ^ op.subt ^ bin;
        r.bout = (~op.minu & op.subt) | (~op.minu & bin) | (op.subt & bin);
        return r;
    endfunction

endpackage

// File: rtl/sersub_cell.sv
module sersub_cell
    import sersub_pkg::*;
(
    input  opnd_t op_i,
    input  logic  bin_i,
    output step_t res_o
);

    always_comb begin
        res_o = fs_step(op_i, bin_i);
    end

endmodule

// File: rtl/sersub_state.sv
module sersub_state
    import sersub_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   en_i,
    input  step_t  nxt_i,
    output state_t q_o
);

    state_t q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= STATE_CLEAR;
        end else if (!en_i) begin
            q <= STATE_CLEAR;
        end else begin
            q.diff   <= nxt_i.diff;
            q.borrow <= nxt_i.bout;
        end
    end

    assign q_o = q;

endmodule

// File: rtl/sersub_lsb.sv
module sersub_lsb
    import sersub_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic a_i,
    input  logic b_i,
    output logic diff_o,
    output logic borrow_o
);

    opnd_t  op;
    step_t  step;
    state_t st;

    assign op.minu = a_i;
    assign op.subt = b_i;

    sersub_cell u_cell (
        .op_i  (op),
        .bin_i (st.borrow),
        .res_o (step)
    );

    sersub_state u_state (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (en_i),
        .nxt_i (step),
        .q_o   (st)
    );

    assign diff_o   = st.diff;
    assign borrow_o = st.borrow;

endmodule

// File: rtl/sersub_lsb_chk.sv
module sersub_lsb_chk (
    input logic clk_i,
    input logic rst_i,
    input logic en_i,
    input logic a_i,
    input logic b_i,
    input logic diff_o,
    input logic borrow_o
);

    AST_DIFF_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (diff_o == ($past(a_i) ^ $past(b_i) ^ $past(borrow_o)))); // R1

    AST_BORROW_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !a_i && b_i) |=> borrow_o); // R2

    AST_BORROW_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && (a_i == b_i)) |=> (borrow_o == $past(borrow_o))); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !diff_o); // R3

    AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !borrow_o); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (!diff_o && !borrow_o)); // R5

endmodule

bind sersub_lsb sersub_lsb_chk u_chk (.*);

// File: tb/tb_sersub_lsb.sv
module tb_sersub_lsb;

    logic clk = 1'b0;
    logic rst, en, a, b;
    logic diff, borrow;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    typedef struct {
        logic d;
        logic bw;
        int   rd;
        int   rb;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    sersub_lsb dut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .a_i(a), .b_i(b),
        .diff_o(diff), .borrow_o(borrow)
    );

    task automatic chk(input logic act, input logic exp, input int req, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Monitor: compares after each edge the item pushed before it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk(diff, it.d, it.rd, "diff_o");
                chk(borrow, it.bw, it.rb, "borrow_o");
            end
        end
    end

    task automatic drive_bit(input logic ea, input logic eb, input logic een,
                             input logic xd, input logic xb, input int rd, input int rb);
        item_t it;
        @(negedge clk);
        a = ea; b = eb; en = een;
        it.d = xd; it.bw = xb; it.rd = rd; it.rb = rb;
        sb.push_back(it);
    endtask

    // One word LSB first (R1, R7 per bit; R2 borrow per prefix; R6 at last bit),
    // then one idle cycle with random operand bits (R3, R4, R8).
    task automatic send_word(input logic [15:0] wa, input logic [15:0] wb, input int n);
        logic [31:0] dw;
        dw = {16'b0, wa} - {16'b0, wb};
        for (int i = 0; i < n; i++) begin
            logic [31:0] m;
            logic xb;
            m  = (32'd1 << (i + 1)) - 32'd1;
            xb = (({16'b0, wa} & m) < ({16'b0, wb} & m));
            drive_bit(wa[i], wb[i], 1'b1, dw[i], xb, 7, (i == n - 1) ? 6 : 2);
        end
        drive_bit(1'($urandom), 1'($urandom), 1'b0, 1'b0, 1'b0, 3, 8);
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; a = 1'b0; b = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(diff, 1'b0, 5, "reset diff");    // R5
        chk(borrow, 1'b0, 5, "reset borrow"); // R5
        @(negedge clk);
        rst = 1'b0;

        // Idle with operand activity: R8
        drive_bit(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3, 8);
        drive_bit(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3, 8);

        send_word(16'd5, 16'd3, 4);
        send_word(16'd3, 16'd5, 4);
        send_word(16'd0, 16'd0, 8);
        send_word(16'h00a5, 16'h00a5, 8);
        send_word(16'd0, 16'd1, 16);   // borrow ripples through every bit
        send_word(16'hffff, 16'd0, 16);
        send_word(16'd1, 16'd2, 2);
        send_word(16'd1, 16'd0, 1);
        send_word(16'd0, 16'd1, 1);
        for (int k = 0; k < 12; k++) begin
            send_word(16'($urandom), 16'($urandom), 16);
        end

        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);

        // Reset mid-word with a borrow pending: R5
        a = 1'b0; b = 1'b1; en = 1'b1;
        repeat (3) @(negedge clk);
        chk(borrow, 1'b1, 2, "borrow before reset");
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk(diff, 1'b0, 5, "reset mid-word diff");
        chk(borrow, 1'b0, 5, "reset mid-word borrow");
        @(negedge clk);
        rst = 1'b0; en = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule